// File: doc/BRIEF.md
# Integer Register Renamer with Idiom Elimination

This block sits between decode and the out-of-order back end. Each cycle it accepts a group of up to `W` integer micro-ops (six by default). It rewrites their architectural register numbers into physical register tags, using a speculative alias table and a free list of physical registers. The renamed group appears on registered outputs one cycle after it is accepted.

Some operations are settled at rename time and need no execution slot. A register-to-register move makes its destination share the source's physical register. A self-XOR or self-subtract sets a known-zero bit in the alias table instead of taking a register. Both kinds are flagged as eliminated on the output. Loading an immediate zero is not treated specially: it is sent as an ordinary ALU op.

A committed alias table is updated by a one-entry-per-cycle retire port. It holds a reference count for every physical register, and a register goes back to the free list when its count falls to zero. A flush rebuilds the speculative table and the free list from the committed state.

Top module: `int_renamer`

## Requirements
- R1: After reset, every architectural register maps to known-zero with tag 0, all physical registers are free, `out_valid` is low and `ren_stall` is low.
- R2: An accepted group appears on the outputs on the next cycle. Op class encoding in `in_kind` is 0 = ALU, 1 = move, 2 = XOR/SUB class, 3 = no destination. Each ALU op gets a new physical register, taking the lowest-numbered free registers in slot order. It is not eliminated and its zero flag is 0.
- R3: A move (class 1) is eliminated. Its destination takes the source's current mapping, tag and zero flag, and no register is allocated.
- R4: A class-2 op whose two sources are the same register is eliminated. Its destination is marked known-zero with tag 0 and nothing is allocated. With different sources it is allocated like an ALU op.
- R5: An immediate-zero load, sent as class 0, gets a normal allocation and is not eliminated.
- R6: A source whose mapping is known-zero is reported with its zero flag set and tag 0.
- R7: Inside a group, each op's sources see the mappings written by earlier slots of the same group.
- R8: A class-3 op renames its sources, allocates nothing, is not eliminated and leaves the alias table unchanged.
- R9: When the free list holds fewer registers than the group's allocating ops need, `ren_stall` is high in that cycle. The group is then not renamed: no output appears and no state changes.
- R10: A retire (`ret_arch`, `ret_tag`, `ret_zero`) writes the committed table, adds one reference to the new register and removes one from the register it replaces. A register shared by several mappings returns to the free list only when its last reference is removed.
- R11: A flush copies the committed table, including any retire in the same cycle, into the speculative table. Every register with no committed reference becomes free again, and any group offered in the flush cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A rename group is offered |
| in_slot_vld | input | W | Per-slot op valid |
| in_kind | input | W×2 | Per-slot op class |
| in_dst | input | W×AW | Destination architectural register |
| in_srca | input | W×AW | First source architectural register |
| in_srcb | input | W×AW | Second source architectural register |
| ren_stall | output | 1 | Group cannot be renamed this cycle |
| ret_vld | input | 1 | Retire one mapping |
| ret_arch | input | AW | Retired architectural register |
| ret_tag | input | PW | Retired physical tag |
| ret_zero | input | 1 | Retired mapping is known-zero |
| flush | input | 1 | Restore speculative state from committed state |
| out_valid | output | 1 | Renamed group valid |
| out_slot_vld | output | W | Per-slot valid of renamed group |
| out_elim | output | W | Op was eliminated at rename |
| out_dtag | output | W×PW | Destination physical tag |
| out_dzero | output | W | Destination is known-zero |
| out_atag | output | W×PW | First source physical tag |
| out_azero | output | W | First source is a ready zero |
| out_btag | output | W×PW | Second source physical tag |
| out_bzero | output | W | Second source is a ready zero |

## Verification
The hardest case to reach from the ports is a physical register shared by several mappings. It must survive the retirement of every overwrite except the last one. The stimulus builds this sharing with a move, retires the whole group, and then overwrites the two architectural registers one at a time with a retire after each. Because the lowest free register is always picked, any early release shows up as a wrong tag on the next allocation. The free list is also driven to exhaustion to produce a stall, and a flush is issued with speculative allocations still in flight.

// File: rtl/renamer_pkg.sv
package renamer_pkg;
  typedef enum logic [1:0] {
    OPK_ALU   = 2'd0,
    OPK_MOVE  = 2'd1,
    OPK_SELF  = 2'd2,
    OPK_NODST = 2'd3
  } opk_e;
endpackage

// File: rtl/rn_free_pick.sv
module rn_free_pick #(
  parameter int NPHYS = 32,
  parameter int W     = 6,
  parameter int PW    = 5,
  parameter int FCW   = 6
)(
  input  logic [NPHYS-1:0]        free_mask,
  output logic [W-1:0][PW-1:0]    pick_tag,
  output logic [FCW-1:0]          free_cnt
);
  // lowest-numbered free registers, one per allocation slot
  always_comb begin
    logic [NPHYS-1:0] avail;
    logic             hit;
    avail = free_mask;
    for (int k = 0; k < W; k++) begin
      pick_tag[k] = '0;
      hit = 1'b0;
      for (int p = 0; p < NPHYS; p++) begin
        if (!hit && avail[p]) begin
          pick_tag[k] = PW'(p);
          avail[p]    = 1'b0;
          hit         = 1'b1;
        end
      end
    end
  end

  always_comb begin
    free_cnt = '0;
    for (int p = 0; p < NPHYS; p++) free_cnt = free_cnt + FCW'(free_mask[p]);
  end
endmodule

// File: rtl/rn_group_map.sv
module rn_group_map
  import renamer_pkg::*;
#(
  parameter int NARCH = 16,
  parameter int NPHYS = 32,
  parameter int W     = 6,
  parameter int AW    = 4,
  parameter int PW    = 5,
  parameter int FCW   = 6
)(
  input  logic                       in_valid,
  input  logic [W-1:0]               slot_vld,
  input  logic [W-1:0][1:0]          kind,
  input  logic [W-1:0][AW-1:0]       dst,
  input  logic [W-1:0][AW-1:0]       srca,
  input  logic [W-1:0][AW-1:0]       srcb,
  input  logic [NARCH-1:0][PW-1:0]   map_tag,
  input  logic [NARCH-1:0]           map_zero,
  input  logic [W-1:0][PW-1:0]       pick_tag,
  output logic [W-1:0]               r_elim,
  output logic [W-1:0][PW-1:0]       r_dtag,
  output logic [W-1:0]               r_dzero,
  output logic [W-1:0][PW-1:0]       r_atag,
  output logic [W-1:0]               r_azero,
  output logic [W-1:0][PW-1:0]       r_btag,
  output logic [W-1:0]               r_bzero,
  output logic [NARCH-1:0][PW-1:0]   nxt_tag,
  output logic [NARCH-1:0]           nxt_zero,
  output logic [NPHYS-1:0]           alloc_mask,
  output logic [FCW-1:0]             need
);
  localparam int KW = $clog2(W + 1);

  // slots walk in program order over a running copy of the map
  always_comb begin
    logic [KW-1:0] k;
    logic          do_alloc;
    logic [PW-1:0] mv_tag;
    logic          mv_zero;
    nxt_tag    = map_tag;
    nxt_zero   = map_zero;
    alloc_mask = '0;
    k          = '0;
    r_elim  = '0; r_dtag  = '0; r_dzero = '0;
    r_atag  = '0; r_azero = '0; r_btag  = '0; r_bzero = '0;
    for (int i = 0; i < W; i++) begin
      do_alloc   = 1'b0;
      r_atag[i]  = nxt_tag[srca[i]];
      r_azero[i] = nxt_zero[srca[i]];
      r_btag[i]  = nxt_tag[srcb[i]];
      r_bzero[i] = nxt_zero[srcb[i]];
      mv_tag     = nxt_tag[srca[i]];
      mv_zero    = nxt_zero[srca[i]];
      if (in_valid && slot_vld[i]) begin
        case (opk_e'(kind[i]))
          OPK_ALU: do_alloc = 1'b1;
          OPK_MOVE: begin
            r_elim[i]       = 1'b1;
            r_dtag[i]       = mv_tag;
            r_dzero[i]      = mv_zero;
            nxt_tag[dst[i]] = mv_tag;
            nxt_zero[dst[i]] = mv_zero;
          end
          OPK_SELF: begin
            if (srca[i] == srcb[i]) begin
              r_elim[i]        = 1'b1;
              r_dzero[i]       = 1'b1;
              nxt_tag[dst[i]]  = '0;
              nxt_zero[dst[i]] = 1'b1;
            end else begin
              do_alloc = 1'b1;
            end
          end
          default: ;
        endcase
      end
      if (do_alloc) begin
        r_dtag[i]                = pick_tag[k];
        nxt_tag[dst[i]]          = pick_tag[k];
        nxt_zero[dst[i]]         = 1'b0;
        alloc_mask[pick_tag[k]]  = 1'b1;
        k = k + 1'b1;
      end
    end
    need = FCW'(k);
  end
endmodule

// File: rtl/rn_commit.sv
module rn_commit #(
  parameter int NARCH = 16,
  parameter int NPHYS = 32,
  parameter int AW    = 4,
  parameter int PW    = 5
)(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ret_vld,
  input  logic [AW-1:0]            ret_arch,
  input  logic [PW-1:0]            ret_tag,
  input  logic                     ret_zero,
  output logic [NARCH-1:0][PW-1:0] cmap_tag_n,
  output logic [NARCH-1:0]         cmap_zero_n,
  output logic [NPHYS-1:0]         cnt_zero_n,
  output logic [NPHYS-1:0]         rel_mask
);
  localparam int CW = $clog2(NARCH + 1);

  logic [NARCH-1:0][PW-1:0] cmap_tag;
  logic [NARCH-1:0]         cmap_zero;
  logic [NPHYS-1:0][CW-1:0] cnt, cnt_n;

  always_comb begin
    logic [PW-1:0] old_t;
    logic          old_z;
    cmap_tag_n  = cmap_tag;
    cmap_zero_n = cmap_zero;
    cnt_n       = cnt;
    rel_mask    = '0;
    old_t       = cmap_tag[ret_arch];
    old_z       = cmap_zero[ret_arch];
    if (ret_vld) begin
      if (!ret_zero) cnt_n[ret_tag] = cnt_n[ret_tag] + CW'(1);
      if (!old_z) begin
        cnt_n[old_t] = cnt_n[old_t] - CW'(1);
        if (cnt_n[old_t] == '0) rel_mask[old_t] = 1'b1;
      end
      cmap_tag_n[ret_arch]  = ret_tag;
      cmap_zero_n[ret_arch] = ret_zero;
    end
    for (int p = 0; p < NPHYS; p++) cnt_zero_n[p] = (cnt_n[p] == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmap_tag  <= '0;
      cmap_zero <= '1;
      cnt       <= '0;
    end else begin
      cmap_tag  <= cmap_tag_n;
      cmap_zero <= cmap_zero_n;
      cnt       <= cnt_n;
    end
  end
endmodule

// File: rtl/int_renamer.sv
module int_renamer #(
  parameter int NARCH = 16,
  parameter int NPHYS = 32,
  parameter int W     = 6,
  localparam int AW   = $clog2(NARCH),
  localparam int PW   = $clog2(NPHYS),
  localparam int FCW  = $clog2(NPHYS + 1)
)(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [W-1:0]          in_slot_vld,
  input  logic [W-1:0][1:0]     in_kind,
  input  logic [W-1:0][AW-1:0]  in_dst,
  input  logic [W-1:0][AW-1:0]  in_srca,
  input  logic [W-1:0][AW-1:0]  in_srcb,
  output logic                  ren_stall,
  input  logic                  ret_vld,
  input  logic [AW-1:0]         ret_arch,
  input  logic [PW-1:0]         ret_tag,
  input  logic                  ret_zero,
  input  logic                  flush,
  output logic                  out_valid,
  output logic [W-1:0]          out_slot_vld,
  output logic [W-1:0]          out_elim,
  output logic [W-1:0][PW-1:0]  out_dtag,
  output logic [W-1:0]          out_dzero,
  output logic [W-1:0][PW-1:0]  out_atag,
  output logic [W-1:0]          out_azero,
  output logic [W-1:0][PW-1:0]  out_btag,
  output logic [W-1:0]          out_bzero
);
  logic [NARCH-1:0][PW-1:0] smap_tag, nxt_tag, cmap_tag_n;
  logic [NARCH-1:0]         smap_zero, nxt_zero, cmap_zero_n;
  logic [NPHYS-1:0]         free_mask, alloc_mask, rel_mask, cnt_zero_n;
  logic [W-1:0][PW-1:0]     pick_tag, g_dtag, g_atag, g_btag;
  logic [W-1:0]             g_elim, g_dzero, g_azero, g_bzero;
  logic [FCW-1:0]           free_cnt, need;
  logic                     fire;

  rn_free_pick #(.NPHYS(NPHYS), .W(W), .PW(PW), .FCW(FCW)) pick_i (
    .free_mask(free_mask), .pick_tag(pick_tag), .free_cnt(free_cnt));

  rn_group_map #(.NARCH(NARCH), .NPHYS(NPHYS), .W(W), .AW(AW), .PW(PW), .FCW(FCW)) map_i (
    .in_valid(in_valid), .slot_vld(in_slot_vld), .kind(in_kind), .dst(in_dst),
    .srca(in_srca), .srcb(in_srcb), .map_tag(smap_tag), .map_zero(smap_zero),
    .pick_tag(pick_tag), .r_elim(g_elim), .r_dtag(g_dtag), .r_dzero(g_dzero),
    .r_atag(g_atag), .r_azero(g_azero), .r_btag(g_btag), .r_bzero(g_bzero),
    .nxt_tag(nxt_tag), .nxt_zero(nxt_zero), .alloc_mask(alloc_mask), .need(need));

  rn_commit #(.NARCH(NARCH), .NPHYS(NPHYS), .AW(AW), .PW(PW)) commit_i (
    .clk(clk), .rst(rst), .ret_vld(ret_vld), .ret_arch(ret_arch), .ret_tag(ret_tag),
    .ret_zero(ret_zero), .cmap_tag_n(cmap_tag_n), .cmap_zero_n(cmap_zero_n),
    .cnt_zero_n(cnt_zero_n), .rel_mask(rel_mask));

  assign ren_stall = in_valid && (free_cnt < need);
  assign fire      = in_valid && !ren_stall && !flush;

  always_ff @(posedge clk) begin
    if (rst) begin
      smap_tag  <= '0;
      smap_zero <= '1;
      free_mask <= '1;
      out_valid <= 1'b0;
    end else begin
      out_valid <= fire;
      if (flush) begin
        smap_tag  <= cmap_tag_n;
        smap_zero <= cmap_zero_n;
        free_mask <= cnt_zero_n;
      end else begin
        if (fire) begin
          smap_tag  <= nxt_tag;
          smap_zero <= nxt_zero;
        end
        free_mask <= (free_mask & ~(fire ? alloc_mask : '0)) | rel_mask;
      end
    end
  end

  always_ff @(posedge clk) begin
    out_slot_vld <= in_slot_vld & {W{in_valid}};
    out_elim     <= g_elim;
    out_dtag     <= g_dtag;
    out_dzero    <= g_dzero;
    out_atag     <= g_atag;
    out_azero    <= g_azero;
    out_btag     <= g_btag;
    out_bzero    <= g_bzero;
  end
endmodule

// File: rtl/int_renamer_chk.sv
module int_renamer_chk #(
  parameter int W  = 6,
  parameter int AW = 4
)(
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic [W-1:0]         in_slot_vld,
  input logic [W-1:0][1:0]    in_kind,
  input logic [W-1:0][AW-1:0] in_srca,
  input logic [W-1:0][AW-1:0] in_srcb,
  input logic                 ren_stall,
  input logic                 flush,
  input logic                 out_valid,
  input logic [W-1:0]         out_elim,
  input logic [W-1:0]         out_dzero
);
  assert_stall_blocks_R9: assert property (@(posedge clk) disable iff (rst)
    ren_stall |=> !out_valid);

  assert_idle_no_stall_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> !ren_stall);

  assert_flush_drops_R11: assert property (@(posedge clk) disable iff (rst)
    flush |=> !out_valid);

  for (genvar g = 0; g < W; g++) begin : g_slot
    assert_move_elim_R3: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_slot_vld[g] && in_kind[g] == 2'd1 && !ren_stall && !flush)
      |=> (out_valid && out_elim[g]));

    assert_self_zero_R4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_slot_vld[g] && in_kind[g] == 2'd2 && in_srca[g] == in_srcb[g]
       && !ren_stall && !flush)
      |=> (out_valid && out_elim[g] && out_dzero[g]));

    assert_alu_alloc_R2: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_slot_vld[g] && in_kind[g] == 2'd0 && !ren_stall && !flush)
      |=> (out_valid && !out_elim[g] && !out_dzero[g]));
  end
endmodule

bind int_renamer int_renamer_chk #(.W(W), .AW(AW)) chk_i (.*);

// File: tb/int_renamer_tb_top.sv
`timescale 1ns/1ps
module int_renamer_tb_top;
  localparam int NARCH = 16;
  localparam int NPHYS = 32;
  localparam int W     = 6;
  localparam int AW    = 4;
  localparam int PW    = 5;

  logic clk, rst, in_valid, ren_stall, ret_vld, ret_zero, flush, out_valid;
  logic [W-1:0]          in_slot_vld, out_slot_vld, out_elim, out_dzero, out_azero, out_bzero;
  logic [W-1:0][1:0]     in_kind;
  logic [W-1:0][AW-1:0]  in_dst, in_srca, in_srcb;
  logic [AW-1:0]         ret_arch;
  logic [PW-1:0]         ret_tag;
  logic [W-1:0][PW-1:0]  out_dtag, out_atag, out_btag;

  int_renamer #(.NARCH(NARCH), .NPHYS(NPHYS), .W(W)) dut_i (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [W-1:0] v, el, dz, az, bz;
    logic [W-1:0][PW-1:0] dt, at, bt;
  } exp_t;
  typedef struct packed { logic [AW-1:0] a; logic [PW-1:0] t; logic z; } ret_t;

  exp_t  expq[$];
  string lblq[$];
  ret_t  pend[$];

  int  m_tag[NARCH]; bit m_zero[NARCH];
  int  c_tag[NARCH]; bit c_zero[NARCH];
  int  cnt[NPHYS];   bit fr[NPHYS];
  bit  s_v[W]; int s_k[W], s_d[W], s_a[W], s_b[W];
  int  checks = 0, errors = 0;
  bit  done = 0;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act %0d exp %0d", rq, what, act, exp);
    end
  endtask

  task automatic set_op(input int s, input int k, input int d, input int a, input int b);
    s_v[s] = 1; s_k[s] = k; s_d[s] = d; s_a[s] = a; s_b[s] = b;
  endtask

  task automatic run_group(input string rq, output bit st);
    exp_t e; int need, nfree;
    @(negedge clk);
    ret_vld = 0; flush = 0; in_valid = 1;
    need = 0; nfree = 0;
    for (int i = 0; i < W; i++) begin
      in_slot_vld[i] = s_v[i]; in_kind[i] = 2'(s_k[i]);
      in_dst[i] = AW'(s_d[i]); in_srca[i] = AW'(s_a[i]); in_srcb[i] = AW'(s_b[i]);
      if (s_v[i] && (s_k[i] == 0 || (s_k[i] == 2 && s_a[i] != s_b[i]))) need++;
    end
    for (int p = 0; p < NPHYS; p++) nfree += int'(fr[p]);
    st = (need > nfree);
    #1;
    chk(ren_stall == st, "R9", {rq, " stall flag"}, int'(ren_stall), int'(st));
    if (!st) begin
      e = '0;
      for (int i = 0; i < W; i++) begin
        if (s_v[i]) begin
          bit al; al = 0;
          e.v[i] = 1;
          e.at[i] = PW'(m_tag[s_a[i]]); e.az[i] = m_zero[s_a[i]];
          e.bt[i] = PW'(m_tag[s_b[i]]); e.bz[i] = m_zero[s_b[i]];
          if (s_k[i] == 0) al = 1;
          else if (s_k[i] == 1) begin
            int t; bit z; t = m_tag[s_a[i]]; z = m_zero[s_a[i]];
            e.el[i] = 1; e.dt[i] = PW'(t); e.dz[i] = z;
            m_tag[s_d[i]] = t; m_zero[s_d[i]] = z;
            pend.push_back('{a: AW'(s_d[i]), t: PW'(t), z: z});
          end else if (s_k[i] == 2) begin
            if (s_a[i] == s_b[i]) begin
              e.el[i] = 1; e.dz[i] = 1; e.dt[i] = '0;
              m_tag[s_d[i]] = 0; m_zero[s_d[i]] = 1;
              pend.push_back('{a: AW'(s_d[i]), t: '0, z: 1'b1});
            end else al = 1;
          end
          if (al) begin
            int p; p = -1;
            for (int q = NPHYS - 1; q >= 0; q--) if (fr[q]) p = q;
            fr[p] = 0;
            e.dt[i] = PW'(p);
            m_tag[s_d[i]] = p; m_zero[s_d[i]] = 0;
            pend.push_back('{a: AW'(s_d[i]), t: PW'(p), z: 1'b0});
          end
        end
      end
      expq.push_back(e); lblq.push_back(rq);
    end
    @(posedge clk); #1;
    in_valid = 0;
    for (int i = 0; i < W; i++) s_v[i] = 0;
  endtask

  task automatic retire_n(input int n);
    for (int j = 0; j < n; j++) begin
      ret_t r;
      if (pend.size() == 0) break;
      r = pend.pop_front();
      @(negedge clk);
      in_valid = 0; flush = 0; ret_vld = 1;
      ret_arch = r.a; ret_tag = r.t; ret_zero = r.z;
      if (!r.z) cnt[r.t]++;
      if (!c_zero[r.a]) begin
        cnt[c_tag[r.a]]--;
        if (cnt[c_tag[r.a]] == 0) fr[c_tag[r.a]] = 1;
      end
      c_tag[r.a] = int'(r.t); c_zero[r.a] = r.z;
      @(posedge clk); #1;
      ret_vld = 0;
    end
  endtask

  task automatic do_flush();
    @(negedge clk);
    in_valid = 1; ret_vld = 0; flush = 1;   // offered group must be dropped (R11)
    for (int i = 0; i < W; i++) begin
      in_slot_vld[i] = 1; in_kind[i] = 2'd0; in_dst[i] = AW'(i);
    end
    for (int a = 0; a < NARCH; a++) begin m_tag[a] = c_tag[a]; m_zero[a] = c_zero[a]; end
    for (int p = 0; p < NPHYS; p++) fr[p] = (cnt[p] == 0);
    pend.delete();
    @(posedge clk); #1;
    flush = 0; in_valid = 0;
  endtask

  task automatic read_all(input string rq);
    bit st;
    for (int base = 0; base < NARCH; base += 2 * W) begin
      for (int i = 0; i < W; i++) set_op(i, 3, 0, (base + 2 * i) % NARCH, (base + 2 * i + 1) % NARCH);
      run_group(rq, st);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (expq.size() == 0) chk(0, "R9", "output with nothing accepted", 1, 0);
      else begin
        exp_t e; string rq;
        e = expq.pop_front(); rq = lblq.pop_front();
        for (int i = 0; i < W; i++) begin
          chk(out_slot_vld[i] == e.v[i], rq, $sformatf("slot%0d vld", i), int'(out_slot_vld[i]), int'(e.v[i]));
          if (e.v[i]) begin
            chk(out_elim[i] == e.el[i], rq, $sformatf("slot%0d elim", i), int'(out_elim[i]), int'(e.el[i]));
            chk(out_dtag[i] == e.dt[i], rq, $sformatf("slot%0d dtag", i), int'(out_dtag[i]), int'(e.dt[i]));
            chk(out_dzero[i] == e.dz[i], rq, $sformatf("slot%0d dzero", i), int'(out_dzero[i]), int'(e.dz[i]));
            chk(out_atag[i] == e.at[i], rq, $sformatf("slot%0d atag", i), int'(out_atag[i]), int'(e.at[i]));
            chk(out_azero[i] == e.az[i], rq, $sformatf("slot%0d azero", i), int'(out_azero[i]), int'(e.az[i]));
            chk(out_btag[i] == e.bt[i], rq, $sformatf("slot%0d btag", i), int'(out_btag[i]), int'(e.bt[i]));
            chk(out_bzero[i] == e.bz[i], rq, $sformatf("slot%0d bzero", i), int'(out_bzero[i]), int'(e.bz[i]));
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL all watchdog expired act 0 exp 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit st;
    rst = 1; in_valid = 0; ret_vld = 0; flush = 0; ret_zero = 0;
    ret_arch = '0; ret_tag = '0;
    in_slot_vld = '0; in_kind = '0; in_dst = '0; in_srca = '0; in_srcb = '0;
    for (int a = 0; a < NARCH; a++) begin m_tag[a] = 0; m_zero[a] = 1; c_tag[a] = 0; c_zero[a] = 1; end
    for (int p = 0; p < NPHYS; p++) begin cnt[p] = 0; fr[p] = 1; end
    for (int i = 0; i < W; i++) s_v[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    chk(out_valid == 0, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(ren_stall == 0, "R1", "ren_stall after reset", int'(ren_stall), 0);

    read_all("R1");

    // R2: plain allocations, lowest free first, with a repeated destination
    set_op(0, 0, 1, 0, 0); set_op(1, 0, 2, 1, 0); set_op(2, 0, 3, 2, 1);
    set_op(3, 0, 4, 3, 3); set_op(4, 0, 1, 1, 4); set_op(5, 0, 5, 1, 2);
    run_group("R2", st);

    // R7: same-group forwarding
    set_op(0, 0, 6, 1, 2); set_op(1, 0, 6, 6, 6); set_op(2, 1, 7, 6, 0);
    set_op(3, 0, 8, 7, 6);
    run_group("R7", st);

    // R3: move chains
    set_op(0, 1, 9, 3, 0); set_op(1, 1, 10, 9, 0); set_op(2, 3, 0, 9, 10);
    run_group("R3", st);

    // R4 and R6: self-op zeroing, unequal self-op, move of a known-zero register
    set_op(0, 2, 11, 4, 4); set_op(1, 2, 12, 4, 5); set_op(2, 3, 0, 11, 12);
    set_op(3, 1, 13, 11, 0); set_op(4, 3, 0, 13, 11);
    run_group("R4", st);

    // R5: immediate zero load is an ordinary ALU op
    set_op(0, 0, 14, 0, 0); set_op(1, 3, 0, 14, 13);
    run_group("R5", st);

    // R8: no-destination ops leave the map untouched
    set_op(0, 3, 11, 11, 14); set_op(1, 3, 14, 14, 11);
    run_group("R8", st);
    read_all("R8");

    retire_n(100);
    for (int i = 0; i < W; i++) set_op(i, 0, i + 1, i, i + 1);
    run_group("R10", st);

    // R9: drain the free list until a group stalls
    for (int g = 0; g < 8; g++) begin
      for (int i = 0; i < W; i++) set_op(i, 0, (g + i) % NARCH, i, 15);
      run_group("R9", st);
      if (st) break;
    end
    chk(st == 1, "R9", "stall reached", int'(st), 1);
    read_all("R9");
    retire_n(12);
    for (int i = 0; i < W; i++) set_op(i, 2, i + 3, i, 15 - i);
    run_group("R10", st);
    retire_n(100);

    // R10: shared register survives until its last mapping is overwritten
    set_op(0, 0, 1, 0, 0); set_op(1, 1, 2, 1, 0);
    run_group("R10", st);
    retire_n(100);
    set_op(0, 0, 1, 2, 2); run_group("R10", st); retire_n(100);
    set_op(0, 0, 3, 2, 1); run_group("R10", st); retire_n(100);
    set_op(0, 0, 2, 0, 0); run_group("R10", st); retire_n(100);
    set_op(0, 0, 4, 1, 2); set_op(1, 0, 5, 4, 4); run_group("R10", st);
    retire_n(100);

    // R11: flush with speculative work outstanding
    for (int i = 0; i < W; i++) set_op(i, 0, i + 6, i, i);
    run_group("R11", st);
    for (int i = 0; i < W; i++) set_op(i, (i % 2 == 0) ? 1 : 0, i, i + 6, 0);
    run_group("R11", st);
    retire_n(3);
    do_flush();
    read_all("R11");
    for (int i = 0; i < W; i++) set_op(i, 0, 15 - i, i, 15 - i);
    run_group("R11", st);

    repeat (3) @(posedge clk);
    #1;
    chk(expq.size() == 0, "R2", "results outstanding", expq.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule